// File: doc/BRIEF.md
# Hold Mode Release Controller

This block manages the light-sleep state of a small microcontroller. When the core issues a hold command, the block reports the core as held while the oscillator, timers, dividers and display driver keep running. Nine wake sources can end the held state: two timer events, two divider events, a pin change on the 4-bit port C, a pin change on the 4-bit port D, falling edges on two external interrupt pins, and a serial transfer-done event. The timers, dividers and serial unit are outside the block and deliver one-cycle pulses.

Each source has two enable bits, an event enable and a hold enable. A source arms only when both are 1. An armed source that fires sets its condition flag. Hardware sets these flags and software clears them, and any set flag ends the held state. Two pin-change status registers record which individual pins of port C and port D caused a port event. Software uses a simple write port to load the enable registers and to clear flags and status bits. It must clear the flags and load the enables before it issues the next hold command.

The state machine has three states. RUN is the normal state. HOLD means the core is stopped. WAKE is a one-cycle exit state that drives the release pulse. The transitions are RUN to HOLD on a hold command, HOLD to WAKE when any condition flag is set, and WAKE to RUN unconditionally. Every other case stays in the current state.

Top module: `hold_wake_ctrl`

## Requirements
- R1: After reset, the enable registers, condition flags and both pin-change status registers read zero, and in_hold and hold_release are 0.
- R2: A write to address 0 loads the event-enable register, and a write to address 1 loads the hold-enable register, both from wr_data[8:0]. The value can be read on the register's output from the next cycle. The bit order for enables and flags is: 0 timer 0, 1 timer 1, 2 divider 0, 3 divider 1, 4 port C, 5 interrupt 0, 6 serial, 7 interrupt 1, 8 port D.
- R3: A condition flag bit sets on the clock edge where its source event is 1 while both of its enable bits are 1. An event from a source that is not armed is ignored and leaves its flag at 0.
- R4: A write to address 2 clears each flag bit where wr_data holds a 1. If an event sets the same bit in the same cycle, the set wins.
- R5: A write that clears an event-enable bit or a hold-enable bit also clears the matching flag bit on the same edge. A flag is never 1 while its source is disarmed.
- R6: A hold_req pulse in RUN moves the block to HOLD, and in_hold reads 1 from the next cycle. If a flag is already set on entry, the block releases on the following cycle.
- R7: In HOLD, a set flag moves the block to WAKE on the next edge. In WAKE, in_hold is 0 and hold_release is 1 for exactly one cycle, and the block then returns to RUN. hold_release is never 1 unless the previous cycle was HOLD, so events in RUN only set flags.
- R8: Each port pin passes through two synchroniser stages. A change in either direction is a pin event, and the port event is the OR of the pin events. For a pin change applied before edge n, the flag and status are visible after edge n+2. While the port is armed, each changed pin is ORed into its status bit (bit i is pin i). A write to address 3 (port C) or address 4 (port D) clears the status bits where wr_data[3:0] holds a 1, and a set in the same cycle wins.
- R9: The interrupt pins are synchronised in the same way. Only a falling edge is an event, with the same latency as R8, and a rising edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | One-cycle hold command from the core |
| tmr_evt | input | 2 | Timer 1/0 event pulses |
| div_evt | input | 2 | Divider 1/0 event pulses |
| ser_done | input | 1 | Serial transfer-done pulse |
| pc_pins | input | 4 | Port C pin levels (asynchronous) |
| pd_pins | input | 4 | Port D pin levels (asynchronous) |
| xint_n | input | 2 | External interrupt pins 1/0, active falling edge |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 3 | Write target: 0 event enable, 1 hold enable, 2 flag clear, 3 port C status clear, 4 port D status clear |
| wr_data | input | 9 | Write data |
| evt_en | output | 9 | Event-enable register |
| hold_en | output | 9 | Hold-enable register |
| cond_flags | output | 9 | Hold-condition flags |
| pc_status | output | 4 | Port C pin-change status |
| pd_status | output | 4 | Port D pin-change status |
| in_hold | output | 1 | Core is held (HOLD state) |
| hold_release | output | 1 | One-cycle pulse on leaving hold |

## Verification
Each source fires in turn. Timer, divider and serial pulses separate the direct event path from the synchronised pin paths. A port D change on two pins at once shows that the status register records several pins, not only one. Events fire with one enable bit cleared and with a rising edge on an interrupt pin, and no flag may appear; this separates the armed path from the ignored path. Events fire both in RUN and in HOLD, and this separates flag setting from release. A flag clear collides with a set in the same cycle, an enable is cleared under a set flag, and hold is entered with a flag already pending; these cases expose the priority of set over clear and the immediate-release path.

// File: rtl/hold_wake_pkg.sv
package hold_wake_pkg;

    localparam int unsigned NUM_SRC = 9;
    localparam int unsigned PORT_W  = 4;

    // Source positions in the enable and flag vectors
    localparam int unsigned SRC_TMR0  = 0;
    localparam int unsigned SRC_TMR1  = 1;
    localparam int unsigned SRC_DIV0  = 2;
    localparam int unsigned SRC_DIV1  = 3;
    localparam int unsigned SRC_PORTC = 4;
    localparam int unsigned SRC_XINT0 = 5;
    localparam int unsigned SRC_SER   = 6;
    localparam int unsigned SRC_XINT1 = 7;
    localparam int unsigned SRC_PORTD = 8;

    typedef enum logic [2:0] {
        ADDR_EVT_EN  = 3'd0,
        ADDR_HOLD_EN = 3'd1,
        ADDR_FLAG_CLR = 3'd2,
        ADDR_PC_CLR  = 3'd3,
        ADDR_PD_CLR  = 3'd4
    } cfg_addr_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAKE = 2'd2
    } hold_state_e;

endpackage

// File: rtl/hold_edge_sync.sv
module hold_edge_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter bit          FALL_ONLY = 1'b0,
    parameter bit          RST_LVL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] evt_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] cur_lvl;

    assign cur_lvl = chain_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= {WIDTH{RST_LVL}};
            end
            prev_q <= {WIDTH{RST_LVL}};
        end else begin
            chain_q[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= cur_lvl;
        end
    end

    generate
        if (FALL_ONLY) begin : g_fall
            assign evt_o = prev_q & ~cur_lvl;
        end else begin : g_any
            assign evt_o = prev_q ^ cur_lvl;
        end
    endgenerate

endmodule

// File: rtl/hold_cond_regs.sv
module hold_cond_regs
    import hold_wake_pkg::*;
#(
    parameter int unsigned NSRC  = NUM_SRC,
    parameter int unsigned PW    = PORT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [NSRC-1:0]     wr_data,
    input  logic [NSRC-1:0]     src_evt,
    input  logic [1:0][PW-1:0]  port_chg,
    output logic [NSRC-1:0]     evt_en_q,
    output logic [NSRC-1:0]     hold_en_q,
    output logic [NSRC-1:0]     cond_q,
    output logic [1:0][PW-1:0]  port_stat_q
);

    logic [NSRC-1:0] evt_en_d;
    logic [NSRC-1:0] hold_en_d;
    logic [NSRC-1:0] armed_d;
    logic [NSRC-1:0] flag_set;
    logic [NSRC-1:0] flag_clr;
    logic [NSRC-1:0] cond_d;

    always_comb begin
        evt_en_d  = evt_en_q;
        hold_en_d = hold_en_q;
        flag_clr  = '0;
        if (wr_en && wr_addr == ADDR_EVT_EN)   evt_en_d  = wr_data;
        if (wr_en && wr_addr == ADDR_HOLD_EN)  hold_en_d = wr_data;
        if (wr_en && wr_addr == ADDR_FLAG_CLR) flag_clr  = wr_data;
        // armed view uses the enables as they stand after this edge
        armed_d  = evt_en_d & hold_en_d;
        flag_set = src_evt & armed_d;
        cond_d   = ((cond_q & ~flag_clr) & armed_d) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_en_q  <= '0;
            hold_en_q <= '0;
            cond_q    <= '0;
        end else begin
            evt_en_q  <= evt_en_d;
            hold_en_q <= hold_en_d;
            cond_q    <= cond_d;
        end
    end

    // One pin-change status register per port
    generate
        for (genvar g = 0; g < 2; g++) begin : g_port
            localparam int unsigned SRC_IDX = (g == 0) ? SRC_PORTC : SRC_PORTD;
            localparam logic [2:0]  CLR_ADR = (g == 0) ? ADDR_PC_CLR : ADDR_PD_CLR;

            logic [PW-1:0] stat_set;
            logic [PW-1:0] stat_clr;

            always_comb begin
                stat_set = port_chg[g] & {PW{armed_d[SRC_IDX]}};
                stat_clr = (wr_en && wr_addr == CLR_ADR) ? wr_data[PW-1:0] : '0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    port_stat_q[g] <= '0;
                end else begin
                    port_stat_q[g] <= (port_stat_q[g] & ~stat_clr) | stat_set;
                end
            end

            // R8: a new status bit needs a pin event on the previous cycle
            assert_stat_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((port_stat_q[g] & ~$past(port_stat_q[g]) & ~$past(port_chg[g])) == '0));
        end
    endgenerate

    // R5: no flag survives while its source is disarmed
    assert_flag_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_q & ~(evt_en_q & hold_en_q)) == '0);

    // R3: a flag only rises after an event on that source
    assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cond_q & ~$past(cond_q) & ~$past(src_evt)) == '0));

    // R4: a flag that was set and received no clear stays set
    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ((($past(cond_q)) & ~cond_q) == '0));

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic any_cond,
    output logic in_hold,
    output logic hold_release
);

    hold_state_e state_q;
    hold_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (hold_req) state_d = ST_HOLD;
            ST_HOLD: if (any_cond) state_d = ST_WAKE;
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        in_hold      = (state_q == ST_HOLD);
        hold_release = (state_q == ST_WAKE);
    end

    // R6: a hold command in RUN reaches HOLD on the next edge
    assert_hold_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hold && !hold_release && hold_req) |=> in_hold);

    // R7: a pending condition in HOLD gives a release pulse next
    assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && any_cond) |=> (hold_release && !in_hold));

    // R7: release only straight after HOLD
    assert_release_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |-> $past(in_hold));

    // R7: release lasts one cycle
    assert_release_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |=> !hold_release);

endmodule

// File: rtl/hold_wake_ctrl.sv
module hold_wake_ctrl
    import hold_wake_pkg::*;
#(
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_req,
    input  logic [1:0]          tmr_evt,
    input  logic [1:0]          div_evt,
    input  logic                ser_done,
    input  logic [PORT_W-1:0]   pc_pins,
    input  logic [PORT_W-1:0]   pd_pins,
    input  logic [1:0]          xint_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [NUM_SRC-1:0]  wr_data,
    output logic [NUM_SRC-1:0]  evt_en,
    output logic [NUM_SRC-1:0]  hold_en,
    output logic [NUM_SRC-1:0]  cond_flags,
    output logic [PORT_W-1:0]   pc_status,
    output logic [PORT_W-1:0]   pd_status,
    output logic                in_hold,
    output logic                hold_release
);

    logic [PORT_W-1:0]         pc_chg;
    logic [PORT_W-1:0]         pd_chg;
    logic [1:0]                xint_fall;
    logic [NUM_SRC-1:0]        src_evt;
    logic [1:0][PORT_W-1:0]    port_chg;
    logic [1:0][PORT_W-1:0]    port_stat;

    hold_edge_sync #(.WIDTH(PORT_W), .STAGES(SYNC_LEN), .FALL_ONLY(1'b0), .RST_LVL(1'b0)) u_sync_pc (
        .clk(clk), .rst_n(rst_n), .pin_i(pc_pins), .evt_o(pc_chg)
    );

    hold_edge_sync #(.WIDTH(PORT_W), .STAGES(SYNC_LEN), .FALL_ONLY(1'b0), .RST_LVL(1'b0)) u_sync_pd (
        .clk(clk), .rst_n(rst_n), .pin_i(pd_pins), .evt_o(pd_chg)
    );

    hold_edge_sync #(.WIDTH(2), .STAGES(SYNC_LEN), .FALL_ONLY(1'b1), .RST_LVL(1'b1)) u_sync_xint (
        .clk(clk), .rst_n(rst_n), .pin_i(xint_n), .evt_o(xint_fall)
    );

    always_comb begin
        src_evt            = '0;
        src_evt[SRC_TMR0]  = tmr_evt[0];
        src_evt[SRC_TMR1]  = tmr_evt[1];
        src_evt[SRC_DIV0]  = div_evt[0];
        src_evt[SRC_DIV1]  = div_evt[1];
        src_evt[SRC_PORTC] = |pc_chg;
        src_evt[SRC_XINT0] = xint_fall[0];
        src_evt[SRC_SER]   = ser_done;
        src_evt[SRC_XINT1] = xint_fall[1];
        src_evt[SRC_PORTD] = |pd_chg;
        port_chg[0]        = pc_chg;
        port_chg[1]        = pd_chg;
    end

    hold_cond_regs #(.NSRC(NUM_SRC), .PW(PORT_W)) u_regs (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .src_evt(src_evt),
        .port_chg(port_chg),
        .evt_en_q(evt_en),
        .hold_en_q(hold_en),
        .cond_q(cond_flags),
        .port_stat_q(port_stat)
    );

    assign pc_status = port_stat[0];
    assign pd_status = port_stat[1];

    hold_fsm u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .hold_req(hold_req),
        .any_cond(|cond_flags),
        .in_hold(in_hold),
        .hold_release(hold_release)
    );

endmodule

// File: tb/hold_wake_ctrl_tb.sv
`timescale 1ns/1ps
module hold_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_req = 1'b0;
    logic [1:0] tmr_evt = '0;
    logic [1:0] div_evt = '0;
    logic       ser_done = 1'b0;
    logic [3:0] pc_pins = '0;
    logic [3:0] pd_pins = '0;
    logic [1:0] xint_n = 2'b11;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [8:0] evt_en, hold_en, cond_flags;
    logic [3:0] pc_status, pd_status;
    logic       in_hold, hold_release;

    always #2.5 clk = ~clk;

    hold_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .tmr_evt(tmr_evt),
        .div_evt(div_evt), .ser_done(ser_done), .pc_pins(pc_pins), .pd_pins(pd_pins),
        .xint_n(xint_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_en(evt_en), .hold_en(hold_en), .cond_flags(cond_flags),
        .pc_status(pc_status), .pd_status(pd_status),
        .in_hold(in_hold), .hold_release(hold_release)
    );

    localparam int K_COND = 0, K_EVTEN = 1, K_HOLDEN = 2, K_PC = 3, K_PD = 4, K_HOLD = 5, K_REL = 6;

    typedef struct {
        int         kind;
        logic [8:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic logic [8:0] observe(int kind);
        case (kind)
            K_COND:   return cond_flags;
            K_EVTEN:  return evt_en;
            K_HOLDEN: return hold_en;
            K_PC:     return {5'd0, pc_status};
            K_PD:     return {5'd0, pd_status};
            K_HOLD:   return {8'd0, in_hold};
            default:  return {8'd0, hold_release};
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [8:0] act;
            it  = sb.pop_front();
            act = observe(it.kind);
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(int kind, logic [8:0] exp, string req);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic enter_hold();
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        expect_val(K_COND, 9'h000, "R1");
        expect_val(K_EVTEN, 9'h000, "R1");
        expect_val(K_PC, 9'h000, "R1");
        expect_val(K_HOLD, 9'h0, "R1");
        expect_val(K_REL, 9'h0, "R1");
        rst_n = 1'b1;
        repeat (4) tick();

        // R2 enable loads
        wr(3'd0, 9'h1FF);
        expect_val(K_EVTEN, 9'h1FF, "R2");
        wr(3'd1, 9'h1FF);
        expect_val(K_HOLDEN, 9'h1FF, "R2");

        // R3 armed timer 0 in RUN sets flag, no release (R7)
        tmr_evt = 2'b01; tick(); tmr_evt = 2'b00;
        expect_val(K_COND, 9'h001, "R3");
        expect_val(K_REL, 9'h0, "R7");
        tick();
        expect_val(K_REL, 9'h0, "R7");
        // R4 clear
        wr(3'd2, 9'h001);
        expect_val(K_COND, 9'h000, "R4");

        // R3 disarmed source is ignored
        wr(3'd0, 9'h1FD);
        tmr_evt = 2'b10; tick(); tmr_evt = 2'b00;
        expect_val(K_COND, 9'h000, "R3");
        wr(3'd0, 9'h1FF);

        // R5 clearing a hold enable drops the flag
        div_evt = 2'b01; tick(); div_evt = 2'b00;
        expect_val(K_COND, 9'h004, "R3");
        wr(3'd1, 9'h1FB);
        expect_val(K_COND, 9'h000, "R5");
        expect_val(K_HOLDEN, 9'h1FB, "R5");
        wr(3'd1, 9'h1FF);

        // R4 set wins over clear
        tmr_evt = 2'b01; wr(3'd2, 9'h001); tmr_evt = 2'b00;
        expect_val(K_COND, 9'h001, "R4");
        wr(3'd2, 9'h1FF);
        expect_val(K_COND, 9'h000, "R4");

        // R6 / R7 hold and divider 1 release
        enter_hold();
        expect_val(K_HOLD, 9'h1, "R6");
        tick();
        expect_val(K_HOLD, 9'h1, "R6");
        div_evt = 2'b10; tick(); div_evt = 2'b00;
        expect_val(K_COND, 9'h008, "R7");
        expect_val(K_HOLD, 9'h1, "R7");
        tick();
        expect_val(K_REL, 9'h1, "R7");
        expect_val(K_HOLD, 9'h0, "R7");
        tick();
        expect_val(K_REL, 9'h0, "R7");
        wr(3'd2, 9'h1FF);

        // R8 port C single pin
        enter_hold();
        pc_pins = 4'b0100;
        tick(); tick(); tick();
        expect_val(K_COND, 9'h010, "R8");
        expect_val(K_PC, 9'h004, "R8");
        tick();
        expect_val(K_REL, 9'h1, "R8");
        wr(3'd2, 9'h1FF);
        wr(3'd3, 9'h00F);
        expect_val(K_PC, 9'h000, "R8");

        // R8 port D two pins together
        enter_hold();
        pd_pins = 4'b1001;
        tick(); tick(); tick();
        expect_val(K_COND, 9'h100, "R8");
        expect_val(K_PD, 9'h009, "R8");
        tick();
        expect_val(K_REL, 9'h1, "R8");
        wr(3'd2, 9'h1FF);
        wr(3'd4, 9'h00F);
        expect_val(K_PD, 9'h000, "R8");

        // R9 interrupt 0 falling edge releases hold
        enter_hold();
        xint_n = 2'b10;
        tick(); tick(); tick();
        expect_val(K_COND, 9'h020, "R9");
        tick();
        expect_val(K_REL, 9'h1, "R9");
        wr(3'd2, 9'h1FF);
        // R9 rising edge ignored
        xint_n = 2'b11;
        repeat (4) tick();
        expect_val(K_COND, 9'h000, "R9");
        // R9 interrupt 1 in RUN: flag only
        xint_n = 2'b01;
        tick(); tick(); tick();
        expect_val(K_COND, 9'h080, "R9");
        expect_val(K_HOLD, 9'h0, "R9");
        wr(3'd2, 9'h1FF);

        // R7 serial release
        enter_hold();
        ser_done = 1'b1; tick(); ser_done = 1'b0;
        expect_val(K_COND, 9'h040, "R7");
        tick();
        expect_val(K_REL, 9'h1, "R7");

        // R6 entry with a flag still pending releases at once
        tick();
        enter_hold();
        expect_val(K_HOLD, 9'h1, "R6");
        tick();
        expect_val(K_REL, 9'h1, "R6");
        expect_val(K_HOLD, 9'h0, "R6");
        wr(3'd2, 9'h1FF);
        expect_val(K_COND, 9'h000, "R4");

        tick(); tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule